// File: doc/BRIEF.md
# Carry-Save Result Queue Converter

This block joins the tail of a chain of word-serial processing elements back to its head. Each cycle the last element may hand over one result word in carry-save form: a sum word and a carry word of `W` bits each, whose true value is their binary sum. If the head element is free, the pair is passed straight on without waiting for an adder. If the head element is still busy with its previous pass, the word is first resolved to plain binary by a carry-propagate adder and then stored in a small FIFO. Each stored entry is therefore `W` bits wide, not `2W` bits.

The head element is fed by a three-way selector. It sees a zero pair on the first cycle of an operation. It sees the bypassed pair when a word can go straight through. It sees a dequeued word when the controller pops the FIFO; that word is presented as a sum word with an all-zero carry word. The adder's carry out is kept from one word to the next within an operand, so multi-word values resolve correctly. The resolved binary word is also driven out as a result of the system.

Top module: `cs_result_queue`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `full_o`=0), `ovf_o` is 0, and the held adder carry is 0.
- R2: While `start_i` is 1, `out_sum_o` and `out_carry_o` are both 0, whatever the other inputs are, and nothing is popped.
- R3: When `start_i`=0, no pop takes place, `in_valid_i`=1 and `pe_busy_i`=0, then `out_sum_o`=`in_sum_i` and `out_carry_o`=`in_carry_i` in the same cycle.
- R4: `bin_o` = (`in_sum_i` + `in_carry_i` + c) mod 2^W. Here c is 0 when `in_first_i`=1. Otherwise c is the carry out of the last word accepted with `in_valid_i`=1.
- R5: A word arriving with `in_valid_i`=1 and `pe_busy_i`=1 is stored as its `bin_o` value. Stored words leave in arrival order.
- R6: When `deq_i`=1, `start_i`=0 and the queue is not empty, the oldest entry is popped. In that cycle `out_sum_o` equals that entry and `out_carry_o`=0. This takes priority over the bypass.
- R7: `full_o` is 1 exactly when `DEPTH` entries are held. `empty_o` is 1 exactly when none are held.
- R8: A write while full is dropped and the stored entries are left unchanged. `ovf_o` rises on the next cycle and stays 1 until reset.
- R9: `deq_i` on an empty queue has no effect on the entry count.
- R10: When neither start, pop nor bypass applies, both outputs to the head element are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | First cycle of an operation; selects a zero pair |
| in_valid_i | input | 1 | A carry-save word is present from the last element |
| in_first_i | input | 1 | The present word is the first word of an operand |
| in_sum_i | input | W | Sum word of the incoming pair |
| in_carry_i | input | W | Carry word of the incoming pair |
| pe_busy_i | input | 1 | Head element is busy; the incoming word is queued |
| deq_i | input | 1 | Pop the oldest queued word to the head element |
| out_sum_o | output | W | Sum word to the head element |
| out_carry_o | output | W | Carry word to the head element |
| bin_o | output | W | Resolved binary value of the incoming word |
| bin_valid_o | output | 1 | `bin_o` is meaningful |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entries |
| ovf_o | output | 1 | Sticky flag: a write was attempted while full |

## Verification
The assertions assume that the controller never asserts `pe_busy_i` and `deq_i` for conflicting purposes. They also assume that `in_first_i` is only meaningful together with `in_valid_i`. The flag checks assume that every queued write comes through `in_valid_i` with `pe_busy_i`. The stimulus changes inputs only on falling edges. It never pops and pushes in the same cycle, except where the bypass priority over a pop is being tested. It drives `in_first_i` at the start of each operand, so the carry history is always defined.

// File: rtl/cs_result_queue.sv
module cs_result_queue #(
  parameter int W = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         in_valid_i,
  input  logic         in_first_i,
  input  logic [W-1:0] in_sum_i,
  input  logic [W-1:0] in_carry_i,
  input  logic         pe_busy_i,
  input  logic         deq_i,
  output logic [W-1:0] out_sum_o,
  output logic [W-1:0] out_carry_o,
  output logic [W-1:0] bin_o,
  output logic         bin_valid_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          cy_q, ovf_q;
  logic [W:0]    cpa;
  logic          cin, push, wr_ok, pop;

  assign cin  = in_first_i ? 1'b0 : cy_q;
  assign cpa  = {1'b0, in_sum_i} + {1'b0, in_carry_i} + {{W{1'b0}}, cin};
  assign bin_o       = cpa[W-1:0];
  assign bin_valid_o = in_valid_i;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign ovf_o   = ovf_q;
  assign push    = in_valid_i & pe_busy_i;
  assign wr_ok   = push & ~full_o;
  assign pop     = deq_i & ~empty_o & ~start_i;

  always_comb begin
    out_sum_o   = '0;
    out_carry_o = '0;
    if (start_i) begin
      out_sum_o   = '0;
      out_carry_o = '0;
    end else if (pop) begin
      out_sum_o   = mem[rd_ptr];
    end else if (in_valid_i && !pe_busy_i) begin
      out_sum_o   = in_sum_i;
      out_carry_o = in_carry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q   <= 1'b0;
      ovf_q  <= 1'b0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (in_valid_i) cy_q <= cpa[W];
      if (push && full_o) ovf_q <= 1'b1;
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)   rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (wr_ok && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !wr_ok) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= bin_o;
  end

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (out_sum_o == '0 && out_carry_o == '0));
  // R4
  first_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_first_i) |-> (bin_o == W'(in_sum_i + in_carry_i)));
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
  // R7
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && in_valid_i && pe_busy_i) |=> !empty_o);
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && pe_busy_i && full_o) |=> ovf_o);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

// File: tb/cs_result_queue_tb.sv
module cs_result_queue_tb;
  localparam int W = 16;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, in_valid_i = 0, in_first_i = 0, pe_busy_i = 0, deq_i = 0;
  logic [W-1:0] in_sum_i = '0, in_carry_i = '0;
  logic [W-1:0] out_sum_o, out_carry_o, bin_o;
  logic bin_valid_o, full_o, empty_o, ovf_o;

  int tests = 0, fails = 0;
  logic cy_m = 0;

  always #5 clk = ~clk;

  cs_result_queue #(.W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_first_i(in_first_i), .in_sum_i(in_sum_i), .in_carry_i(in_carry_i),
    .pe_busy_i(pe_busy_i), .deq_i(deq_i), .out_sum_o(out_sum_o),
    .out_carry_o(out_carry_o), .bin_o(bin_o), .bin_valid_o(bin_valid_o),
    .full_o(full_o), .empty_o(empty_o), .ovf_o(ovf_o));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, settle, return expected bin value; model carry
  task automatic drive(input logic st, input logic v, input logic f, input logic [W-1:0] s,
                       input logic [W-1:0] c, input logic busy, input logic dq,
                       output logic [W-1:0] expb);
    logic [W:0] t;
    @(negedge clk);
    start_i = st; in_valid_i = v; in_first_i = f; in_sum_i = s; in_carry_i = c;
    pe_busy_i = busy; deq_i = dq;
    #1;
    t = {1'b0, s} + {1'b0, c} + {{W{1'b0}}, (f ? 1'b0 : cy_m)};
    expb = t[W-1:0];
    if (v) cy_m = t[W];
  endtask

  task automatic idle();
    logic [W-1:0] e;
    drive(0, 0, 0, '0, '0, 0, 0, e);
  endtask

  task automatic t_reset();
    chk("R1 empty", W'(empty_o), 1);
    chk("R1 full", W'(full_o), 0);
    chk("R1 ovf", W'(ovf_o), 0);
    chk("R10 sum", out_sum_o, 0);
    chk("R10 carry", out_carry_o, 0);
  endtask

  task automatic t_start();
    logic [W-1:0] e;
    drive(1, 1, 1, 16'h0005, 16'h0003, 0, 1, e);
    chk("R2 sum", out_sum_o, 0);
    chk("R2 carry", out_carry_o, 0);
    chk("R4 bin", bin_o, e);
    idle();
    chk("R9 empty", W'(empty_o), 1);
  endtask

  task automatic t_bypass();
    logic [W-1:0] e;
    drive(0, 1, 1, 16'h1234, 16'h0F0F, 0, 0, e);
    chk("R3 sum", out_sum_o, 16'h1234);
    chk("R3 carry", out_carry_o, 16'h0F0F);
    chk("R4 bin", bin_o, 16'h2143);
    idle();
  endtask

  task automatic t_chain();
    logic [W-1:0] e;
    drive(0, 1, 1, 16'hFFFF, 16'h0002, 0, 0, e);
    chk("R4 wrap", bin_o, 16'h0001);
    idle();
    drive(0, 1, 0, 16'h0010, 16'h0000, 0, 0, e);
    chk("R4 carry in", bin_o, 16'h0011);
    drive(0, 1, 1, 16'hFFF0, 16'h0020, 0, 0, e);
    chk("R4 first clears", bin_o, 16'h0010);
    drive(0, 1, 1, 16'h0001, 16'h0000, 0, 0, e);
    chk("R4 first clears 2", bin_o, 16'h0001);
    idle();
  endtask

  task automatic t_queue_order();
    logic [W-1:0] e0, e1, e2, e;
    drive(0, 1, 1, 16'hFFFF, 16'h0003, 1, 0, e0);
    drive(0, 1, 0, 16'h00A0, 16'h0005, 1, 0, e1);
    drive(0, 1, 0, 16'h1111, 16'h2222, 1, 0, e2);
    chk("R5 carry chained", e1, 16'h00A6);
    idle();
    chk("R7 not empty", W'(empty_o), 0);
    chk("R7 not full", W'(full_o), 0);
    // pop has priority over a bypass candidate
    drive(0, 1, 1, 16'hBEEF, 16'h0101, 0, 1, e);
    chk("R6 head", out_sum_o, e0);
    chk("R6 carry zero", out_carry_o, 0);
    drive(0, 0, 0, '0, '0, 0, 1, e);
    chk("R5 second", out_sum_o, e1);
    drive(0, 0, 0, '0, '0, 0, 1, e);
    chk("R5 third", out_sum_o, e2);
    idle();
    chk("R7 empty again", W'(empty_o), 1);
    chk("R10 idle sum", out_sum_o, 0);
  endtask

  task automatic t_full_ovf();
    logic [W-1:0] ev [DEPTH];
    logic [W-1:0] e;
    for (int i = 0; i < DEPTH; i++)
      drive(0, 1, 1, W'(16'h0100 * (i + 1)), W'(i), 1, 0, ev[i]);
    idle();
    chk("R7 full", W'(full_o), 1);
    chk("R8 no ovf yet", W'(ovf_o), 0);
    drive(0, 1, 1, 16'h7777, 16'h0000, 1, 0, e);
    idle();
    chk("R8 ovf set", W'(ovf_o), 1);
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, 0, 0, '0, '0, 0, 1, e);
      chk("R8 contents kept", out_sum_o, ev[i]);
    end
    idle();
    chk("R7 empty after drain", W'(empty_o), 1);
    chk("R8 ovf sticky", W'(ovf_o), 1);
  endtask

  task automatic t_empty_deq();
    logic [W-1:0] e, e1;
    drive(0, 0, 0, '0, '0, 0, 1, e);
    chk("R9 empty deq sum", out_sum_o, 0);
    drive(0, 0, 0, '0, '0, 0, 1, e);
    drive(0, 1, 1, 16'h4321, 16'h0001, 1, 0, e1);
    idle();
    chk("R9 one entry", W'(empty_o), 0);
    drive(0, 0, 0, '0, '0, 0, 1, e);
    chk("R9 value", out_sum_o, e1);
    idle();
    chk("R9 empty after one pop", W'(empty_o), 1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_start();
    t_bypass();
    t_chain();
    t_queue_order();
    t_empty_deq();
    t_full_ovf();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule